// File: doc/BRIEF.md
# Serial Flash Clock and Chip-Select Timing Controller

This block stands between a command engine and the clock and select pins of an external serial flash. For every accepted command it pulls the active-low chip-select down. It then produces one serial clock period per requested bit, where a serial period is two system cycles, and it releases the select afterwards. A one-cycle done pulse marks the release. Before the next command may begin, the block holds the select high for a programmable number of serial cycles.

Several settings come from configuration inputs. These are the resting level of the clock between commands (low or high), an option that keeps the clock toggling at all times, the minimum deselect gap, the device size and a memory kind. The device size limits which address bits reach the output. The memory kind selects which byte of a 16-bit double-rate word goes out first. The block takes new configuration only while it is idle, so a change made during a command first applies to the next one.

Top module: `spi_clkcs_ctrl`

## Requirements
- R1: While chip-select is high and `cfg_free_run` is 0, `sck` equals `cfg_clk_mode3` (0 rests low, 1 rests high).
- R2: While idle with `cfg_free_run` = 1, `sck` changes on every system cycle. While chip-select is low, `sck` gives exactly max(`req_bits`,1) rising edges whatever the free-run setting.
- R3: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `cs_n` is low from the next cycle onward for exactly 2*max(`req_bits`,1) system cycles, so a bit count of 0 acts as 1.
- R4: Between two commands, `cs_n` stays high for at least 2*(`cfg_gap`+1) system cycles. A request that arrives during the gap is stalled with `req_ready` low and is not dropped. If the request is already waiting, the gap is exactly that long.
- R5: In the reduced build (`EXT_GAP` = 0), only `cfg_gap[2:0]` counts, so the gap is 2*(`cfg_gap[2:0]`+1) system cycles.
- R6: While `cs_n` is low, `addr_out` equals the accepted `req_addr` with every bit above index `cfg_dev_size` cleared. The device then holds 2^(size+1) bytes.
- R7: `word_out[15:8]` carries the byte sent first. For `cfg_mem_type` 1 or 3, the first byte is `word_in[15:8]` (D1). For all other kinds it is `word_in[7:0]` (D0).
- R8: `done` is 1 for exactly one system cycle: the first cycle in which `cs_n` is high again after a command.
- R9: Changes to the configuration during a command leave that command's idle level, byte order and address mask unchanged. They take effect once the block is idle.
- R10: While and after reset, `cs_n` is 1, `done` is 0, `sck` is 0 with zero configuration inputs, and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clk_mode3 | input | 1 | Clock resting level between commands (1 = high) |
| cfg_free_run | input | 1 | Keep the clock toggling while idle |
| cfg_gap | input | 6 | Deselect gap minus one, in serial cycles |
| cfg_dev_size | input | 5 | Device size code; size+1 address bits are significant |
| cfg_mem_type | input | 3 | Memory kind; 1 and 3 send D1 first |
| req_valid | input | 1 | Command request |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_bits | input | CNT_W | Number of serial clock periods in the command |
| req_addr | input | ADDR_W | Command start address |
| word_in | input | 16 | Double-rate word, D0 in [7:0], D1 in [15:8] |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip-select |
| addr_out | output | ADDR_W | Address masked to the device size |
| word_out | output | 16 | Word reordered so [15:8] goes first |
| done | output | 1 | One-cycle pulse at select release |

## Verification
Each symptom points to a particular register. A bit counter that is off by one makes the select window two cycles longer or shorter and changes the rising-edge count, and this is seen at the first release after the command starts. A deselect counter loaded with the wrong value, or reading the wrong field bits, shows up in the measured high time between back-to-back commands, once the second command is accepted. The two builds are compared on the same stalled request stream. A configuration register that is captured at the wrong moment shows up within one cycle as a changed byte order or resting level while the select is still low.

// File: rtl/spi_tim_pkg.sv
package spi_tim_pkg;

  localparam int GAP_W  = 6;
  localparam int SIZE_W = 5;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    MK_D0_FIRST  = 3'd0,
    MK_D1_FIRST  = 3'd1,
    MK_PLAIN     = 3'd2,
    MK_D1_RAM    = 3'd3,
    MK_LINK_MEM  = 3'd4,
    MK_LINK_REG  = 3'd5
  } mem_kind_e;

  typedef struct packed {
    logic              idle_high;
    logic              clk_always;
    logic [GAP_W-1:0]  gap;
    logic [SIZE_W-1:0] size;
    logic [KIND_W-1:0] kind;
  } tim_cfg_t;

  function automatic logic d1_leads(input logic [KIND_W-1:0] kind);
    return (kind == MK_D1_FIRST) || (kind == MK_D1_RAM);
  endfunction

endpackage

// File: rtl/spi_gap_timer.sv
module spi_gap_timer #(
  parameter int GAP_W   = 6,
  parameter bit EXT_GAP = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GAP_W-1:0] gap,
  output logic             expired
);
  localparam int CW = GAP_W + 1;

  logic [GAP_W-1:0] gap_eff;
  logic [CW-1:0]    cnt_q, cnt_d;

  generate
    if (EXT_GAP) begin : g_full
      assign gap_eff = gap;
    end else begin : g_short
      assign gap_eff = {{(GAP_W-3){1'b0}}, gap[2:0]};
    end
  endgenerate

  // load 2*(gap+1)-1 so the counter reaches zero in the last required high cycle
  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = {gap_eff, 1'b1};
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  AST_GAP_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !expired); // R4

endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] bits,
  input  logic             free_run,
  input  logic             idle_high,
  output logic             sck,
  output logic             active,
  output logic             last
);
  logic             act_q, act_d;
  logic             ph_q, ph_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic [CNT_W-1:0] bits_eff;

  assign bits_eff = (bits == '0) ? CNT_W'(1) : bits;
  assign last     = act_q && ph_q && (left_q == CNT_W'(1));

  always_comb begin
    act_d  = act_q;
    ph_d   = ph_q;
    left_d = left_q;
    if (start) begin
      act_d  = 1'b1;
      ph_d   = 1'b0;
      left_d = bits_eff;
    end else if (act_q) begin
      ph_d = ~ph_q;
      if (ph_q)  left_d = left_q - 1'b1;
      if (last)  act_d  = 1'b0;
    end else begin
      ph_d = free_run ? ~ph_q : 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      ph_q   <= 1'b0;
      left_q <= '0;
    end else begin
      act_q  <= act_d;
      ph_q   <= ph_d;
      left_q <= left_d;
    end
  end

  assign active = act_q;
  assign sck    = (act_q || free_run) ? ph_q : idle_high;

  AST_LEFT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (left_q != '0)); // R3

endmodule

// File: rtl/spi_addr_mask.sv
module spi_addr_mask #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size,
  output logic [ADDR_W-1:0] addr_o
);
  generate
    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
      localparam int unsigned IDX = i;
      assign addr_o[i] = addr_i[i] & (IDX <= 32'(size));
    end
  endgenerate
endmodule

// File: rtl/spi_clkcs_ctrl.sv
module spi_clkcs_ctrl
  import spi_tim_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 16,
  parameter bit EXT_GAP = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_clk_mode3,
  input  logic              cfg_free_run,
  input  logic [GAP_W-1:0]  cfg_gap,
  input  logic [SIZE_W-1:0] cfg_dev_size,
  input  logic [KIND_W-1:0] cfg_mem_type,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CNT_W-1:0]  req_bits,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       word_in,
  output logic              sck,
  output logic              cs_n,
  output logic [ADDR_W-1:0] addr_out,
  output logic [15:0]       word_out,
  output logic              done
);
  tim_cfg_t          cfg_in, cfg_q, cfg_d, cfg_eff;
  logic              busy, last, start, gap_free;
  logic [ADDR_W-1:0] addr_masked, addr_q, addr_d;
  logic              done_q, done_d;

  assign cfg_in = '{idle_high:  cfg_clk_mode3,
                    clk_always: cfg_free_run,
                    gap:        cfg_gap,
                    size:       cfg_dev_size,
                    kind:       cfg_mem_type};

  // settings follow the inputs while idle and freeze for a command
  assign cfg_eff   = busy ? cfg_q : cfg_in;
  assign req_ready = !busy && gap_free;
  assign start     = req_valid && req_ready;

  spi_sck_gen #(.CNT_W(CNT_W)) u_sck (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .bits      (req_bits),
    .free_run  (cfg_eff.clk_always),
    .idle_high (cfg_eff.idle_high),
    .sck       (sck),
    .active    (busy),
    .last      (last)
  );

  spi_gap_timer #(.GAP_W(GAP_W), .EXT_GAP(EXT_GAP)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (last),
    .gap     (cfg_q.gap),
    .expired (gap_free)
  );

  spi_addr_mask #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_mask (
    .addr_i (req_addr),
    .size   (cfg_eff.size),
    .addr_o (addr_masked)
  );

  always_comb begin
    cfg_d  = busy  ? cfg_q : cfg_in;
    addr_d = start ? addr_masked : addr_q;
    done_d = last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      addr_q <= addr_d;
      done_q <= done_d;
    end
  end

  assign cs_n     = ~busy;
  assign done     = done_q;
  assign addr_out = addr_q;
  assign word_out = d1_leads(cfg_eff.kind) ? word_in : {word_in[7:0], word_in[15:8]};

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !cfg_free_run) |-> (sck == cfg_clk_mode3)); // R1
  AST_CS_FALL_HS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(req_valid && req_ready)); // R3
  AST_GAP_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> !req_ready); // R4
  AST_ADDR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> ((addr_out >> (32'(cfg_q.size) + 1)) == '0)); // R6
  AST_DONE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !$past(cs_n))); // R8
  AST_RISE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> done); // R8
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$past(cs_n)) |-> $stable(cfg_q)); // R9

endmodule

// File: tb/test_spi_clkcs_ctrl.sv
module test_cs_mon (
  input  logic clk,
  input  logic cs_n,
  input  logic sck,
  input  logic done,
  output int   n_end,
  output int   low_len,
  output int   rises,
  output int   n_fall,
  output int   gap_len,
  output int   bad_done
);
  logic pcs = 1'b1, psck = 1'b0;
  int lc = 0, rc = 0, hc = 0;
  int e_r = 0, ll_r = 0, ri_r = 0, f_r = 0, g_r = 0, bd_r = 0;

  always @(negedge clk) begin
    if (!cs_n) begin
      if (pcs) begin f_r++; g_r = hc; lc = 1; rc = 0; end
      else begin
        lc++;
        if (!psck && sck) rc++;
      end
    end else begin
      if (!pcs) begin
        e_r++; ll_r = lc; ri_r = rc; hc = 1;
        if (!done) bd_r++;
      end else begin
        hc++;
        if (done) bd_r++;
      end
    end
    pcs  = cs_n;
    psck = sck;
  end

  assign n_end = e_r;   assign low_len = ll_r; assign rises    = ri_r;
  assign n_fall = f_r;  assign gap_len = g_r;  assign bad_done = bd_r;
endmodule

module test_spi_clkcs_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_clk_mode3 = 0, cfg_free_run = 0;
  logic [5:0] cfg_gap = '0;
  logic [4:0] cfg_dev_size = '0;
  logic [2:0] cfg_mem_type = '0;
  logic req_valid = 0;
  logic [CNT_W-1:0] req_bits = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [15:0] word_in = '0;
  logic req_ready, sck, cs_n, done, ready_b, sck_b, cs_n_b, done_b;
  logic [ADDR_W-1:0] addr_out, addr_b;
  logic [15:0] word_out, word_b;
  int checks = 0, errors = 0;
  int a_end, a_low, a_rise, a_fall, a_gap, a_bad;
  int b_end, b_low, b_rise, b_fall, b_gap, b_bad;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_clkcs_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .EXT_GAP(1'b1)) i_spi_clkcs_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_clk_mode3(cfg_clk_mode3), .cfg_free_run(cfg_free_run),
    .cfg_gap(cfg_gap), .cfg_dev_size(cfg_dev_size), .cfg_mem_type(cfg_mem_type),
    .req_valid(req_valid), .req_ready(req_ready), .req_bits(req_bits), .req_addr(req_addr),
    .word_in(word_in), .sck(sck), .cs_n(cs_n), .addr_out(addr_out), .word_out(word_out),
    .done(done));

  spi_clkcs_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .EXT_GAP(1'b0)) i_spi_clkcs_ctrl_rb (
    .clk(clk), .rst_n(rst_n), .cfg_clk_mode3(cfg_clk_mode3), .cfg_free_run(cfg_free_run),
    .cfg_gap(cfg_gap), .cfg_dev_size(cfg_dev_size), .cfg_mem_type(cfg_mem_type),
    .req_valid(req_valid), .req_ready(ready_b), .req_bits(req_bits), .req_addr(req_addr),
    .word_in(word_in), .sck(sck_b), .cs_n(cs_n_b), .addr_out(addr_b), .word_out(word_b),
    .done(done_b));

  test_cs_mon mon_a (.clk(clk), .cs_n(cs_n), .sck(sck), .done(done), .n_end(a_end),
    .low_len(a_low), .rises(a_rise), .n_fall(a_fall), .gap_len(a_gap), .bad_done(a_bad));
  test_cs_mon mon_b (.clk(clk), .cs_n(cs_n_b), .sck(sck_b), .done(done_b), .n_end(b_end),
    .low_len(b_low), .rises(b_rise), .n_fall(b_fall), .gap_len(b_gap), .bad_done(b_bad));

  task automatic check(input string req, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] exp_addr(input logic [ADDR_W-1:0] a, input logic [4:0] s);
    logic [63:0] m = (64'd1 << (32'(s) + 1)) - 64'd1;
    return a & m[ADDR_W-1:0];
  endfunction

  function automatic logic [15:0] exp_word(input logic [15:0] w, input logic [2:0] mt);
    return (mt == 3'd1 || mt == 3'd3) ? w : {w[7:0], w[15:8]};
  endfunction

  task automatic do_cmd(input int bits, input logic [31:0] addr, input logic [15:0] w);
    int n0, nb;
    @(posedge clk); #1;
    req_valid = 1'b1; req_bits = CNT_W'(bits); req_addr = addr; word_in = w;
    do @(negedge clk); while (!req_ready);
    n0 = a_end;
    @(posedge clk); #1 req_valid = 1'b0;
    @(negedge clk);
    check("R3 cs low after accept", cs_n == 1'b0, cs_n, 0);
    check("R6 masked address", addr_out == exp_addr(addr, cfg_dev_size), addr_out, exp_addr(addr, cfg_dev_size));
    check("R7 byte order", word_out == exp_word(w, cfg_mem_type), word_out, exp_word(w, cfg_mem_type));
    while (a_end == n0) @(posedge clk);
    nb = (bits == 0) ? 1 : bits;
    check("R3 cs low length", a_low == 2*nb, a_low, 2*nb);
    check("R2 rising edges in command", a_rise == nb, a_rise, nb);
  endtask

  task automatic gap_run(input logic [5:0] g);
    int fa, fb, ea;
    @(posedge clk); #1;
    cfg_gap = g; req_bits = 16'd1; req_valid = 1'b1;
    fa = a_fall; fb = b_fall; ea = a_end;
    while ((a_fall < fa + 3) || (b_fall < fb + 3)) begin
      @(posedge clk);
      if (a_end != ea && g != 0) begin
        ea = a_end;
        @(negedge clk);
        check("R4 ready low in gap", !(req_ready && cs_n), req_ready, 0);
      end
    end
    #1 req_valid = 1'b0;
    check("R4 gap length", a_gap == 2*(int'(g)+1), a_gap, 2*(int'(g)+1));
    check("R5 reduced gap length", b_gap == 2*(int'(g[2:0])+1), b_gap, 2*(int'(g[2:0])+1));
    repeat (140) @(posedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", checks, -1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ok, chg;
    logic ps;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset cs_n", cs_n == 1'b1, cs_n, 1);
    check("R10 reset done", done == 1'b0, done, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check("R10 post-reset sck", sck == 1'b0, sck, 0);
    check("R10 post-reset ready", req_ready == 1'b1, req_ready, 1);
    check("R10 post-reset cs_n", cs_n == 1'b1, cs_n, 1);

    // R1 resting levels
    @(posedge clk); #1 cfg_clk_mode3 = 1'b1;
    ok = 1;
    repeat (6) begin @(negedge clk); if (sck !== 1'b1) ok = 0; end
    check("R1 rest high", ok == 1, ok, 1);
    @(posedge clk); #1 cfg_clk_mode3 = 1'b0;
    ok = 1;
    repeat (6) begin @(negedge clk); if (sck !== 1'b0) ok = 0; end
    check("R1 rest low", ok == 1, ok, 1);

    // R2 free running clock while idle
    @(posedge clk); #1 cfg_free_run = 1'b1;
    @(negedge clk); ps = sck; chg = 0;
    repeat (8) begin @(negedge clk); if (sck != ps) chg++; ps = sck; end
    check("R2 free toggles", chg == 8, chg, 8);
    do_cmd(5, 32'h1234_5678, 16'hA55A);
    @(posedge clk); #1 cfg_free_run = 1'b0;

    // R3 zero bit count, R6 size corners, R7 kinds
    cfg_dev_size = 5'd0;  do_cmd(0, 32'hFFFF_FFFF, 16'h1234);
    cfg_dev_size = 5'd31; cfg_mem_type = 3'd1; do_cmd(3, 32'hDEAD_BEEF, 16'h1234);
    cfg_dev_size = 5'd23; cfg_mem_type = 3'd3; do_cmd(2, 32'hFFFF_FFFF, 16'hBEEF);
    cfg_dev_size = 5'd7;  cfg_mem_type = 3'd4; do_cmd(4, 32'h0000_0FFF, 16'hBEEF);

    // R9 changes during a command wait for idle
    @(posedge clk); #1;
    cfg_mem_type = 3'd0; cfg_clk_mode3 = 1'b0; cfg_dev_size = 5'd3;
    req_valid = 1'b1; req_bits = 16'd6; req_addr = 32'hFF; word_in = 16'h00FF;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0; cfg_mem_type = 3'd1; cfg_clk_mode3 = 1'b1; cfg_dev_size = 5'd31;
    @(negedge clk);
    check("R9 order frozen", word_out == 16'hFF00, word_out, 16'hFF00);
    check("R9 mask frozen", addr_out == 32'h0F, addr_out, 32'h0F);
    while (!cs_n) @(negedge clk);
    @(negedge clk);
    check("R9 new order when idle", word_out == 16'h00FF, word_out, 16'h00FF);
    check("R9 new rest level when idle", sck == 1'b1, sck, 1);
    check("R8 single done pulse", done == 1'b0, done, 0);

    // R4 / R5 deselect gaps with a waiting request
    gap_run(6'd0);
    gap_run(6'd5);
    gap_run(6'd13);
    gap_run(6'd63);
    cfg_gap = '0;

    // random commands
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #1;
      cfg_clk_mode3 = 1'($urandom);
      cfg_free_run  = 1'($urandom);
      cfg_gap       = 6'($urandom_range(0, 3));
      cfg_dev_size  = 5'($urandom);
      cfg_mem_type  = 3'($urandom_range(0, 5));
      do_cmd(int'($urandom_range(0, 24)), $urandom, 16'($urandom));
    end

    repeat (10) @(posedge clk);
    check("R8 done only at cs rise", a_bad == 0, a_bad, 0);
    check("R8 done only at cs rise reduced", b_bad == 0, b_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule